// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block divides a chosen source clock by a programmable factor and hands a one-cycle tick to a group of three timers. A 24-bit control word holds a 21-bit reload value and a 2-bit source choice. The top bit of the word always reads as zero. The source is either an internal strobe that fires on every second system clock, or the rising or falling edges of an external pin. Before use, that pin passes through a two-flop synchronizer and an edge detector.

The down-counter runs only while at least one timer has both its enable bit and its prescaler-select bit set. If the reload value is N, a tick appears once every N+1 source events. The counter loads the reload value when it wraps past zero and again each time it goes from stopped to running. A source change written while the counter runs is dropped. A reload value written while it runs is taken at the next reload.

Top module: `timer_prescaler`

## Requirements
- R1: A write stores wr_data[20:0] as the reload value and wr_data[22:21] as the source code. rd_data returns {0, source, reload}, and bit 23 is always 0. Hardware reset clears both fields.
- R2: A clock edge with soft_rst high clears the reload value and the source code to zero. This takes priority over a write in the same cycle.
- R3: The counter runs only while some index i has both tmr_en[i] and tmr_psel[i] high. An enable without a select on the same timer does not start it.
- R4: With reload value N, tick pulses once for every N+1 source events. The pulse is one system clock wide and appears on the clock after the event that wraps the count from zero.
- R5: On the first clock where the counter runs after being stopped, the count loads the reload value. No event is counted on that clock.
- R6: While the counter is stopped, the count holds and tick stays low.
- R7: Source code 00 gives one event on every second clock while running. The first event is on the second clock after the start.
- R8: Source code 01 counts rising edges of ext_pin and code 10 counts falling edges. Each edge is counted once, on the third clock edge after the pin changes.
- R9: Source code 11 gives no events, so tick stays low.
- R10: While the counter runs, a write leaves the source code unchanged but still updates the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous reset of the control fields |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 24 | Control word write data |
| rd_data | output | 24 | Control word read value |
| tmr_en | input | 3 | Per-timer enable bits |
| tmr_psel | input | 3 | Per-timer prescaler-select bits |
| ext_pin | input | 1 | External source pin, asynchronous |
| tick | output | 1 | One-cycle prescaler output pulse |

## Verification
The divide is run with reload values 3, 0, 2 and 1, on the internal strobe and on both edge sources. Counting ticks over a known number of events catches an off-by-one in the divide factor and separates rising-edge counting from falling-edge counting. A stop part-way through a period, followed by a restart, shows whether the count reloads or carries on from where it stopped. Enable and select bits set on different timers check that the run condition pairs them per timer. Writes made while running check that the source code is frozen and the reload value is not. A behavioural model compared on every clock pins down the exact cycle of each tick.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
  typedef enum logic [1:0] {
    SRC_INT_DIV2 = 2'b00,
    SRC_EXT_RISE = 2'b01,
    SRC_EXT_FALL = 2'b10,
    SRC_NONE     = 2'b11
  } src_e;
endpackage

// File: rtl/tp_ctrl_reg.sv
`timescale 1ns/1ps
module tp_ctrl_reg
  import tp_pkg::*;
#(
  parameter int PL_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_en,
  input  logic [PL_W-1:0] wr_pl,
  input  logic [1:0]      wr_src,
  input  logic            run,
  output logic [PL_W-1:0] pl,
  output src_e            src
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl  <= '0;
      src <= SRC_INT_DIV2;
    end else if (soft_rst) begin
      pl  <= '0;
      src <= SRC_INT_DIV2;
    end else if (wr_en) begin
      pl <= wr_pl;
      if (!run) src <= src_e'(wr_src);
    end
  end
endmodule

// File: rtl/tp_edge_sync.sv
`timescale 1ns/1ps
module tp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], pin};
  end

  logic synced, prev;
  assign synced = sh[STAGES-1];
  assign prev   = sh[STAGES];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;
endmodule

// File: rtl/tp_src_sel.sv
`timescale 1ns/1ps
module tp_src_sel
  import tp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  src_e src,
  input  logic rise,
  input  logic fall,
  output logic ev
);
  logic half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= run ? ~half : 1'b0;
  end

  always_comb begin
    unique case (src)
      SRC_INT_DIV2: ev = run & half;
      SRC_EXT_RISE: ev = run & rise;
      SRC_EXT_FALL: ev = run & fall;
      default:      ev = 1'b0;
    endcase
  end
endmodule

// File: rtl/tp_counter.sv
`timescale 1ns/1ps
module tp_counter #(
  parameter int PL_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ev,
  input  logic [PL_W-1:0] pl,
  output logic [PL_W-1:0] cnt,
  output logic            start,
  output logic            wrap,
  output logic            tick
);
  function automatic logic [PL_W-1:0] next_count(input logic [PL_W-1:0] c,
                                                 input logic [PL_W-1:0] p);
    return (c == '0) ? p : c - 1'b1;
  endfunction

  logic run_q;

  assign start = run & ~run_q;
  assign wrap  = ev & ~start & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      run_q <= run;
      tick  <= wrap;
      if (start)   cnt <= pl;
      else if (ev) cnt <= next_count(cnt, pl);
    end
  end
endmodule

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler
  import tp_pkg::*;
#(
  parameter int NUM_TMR     = 3,
  parameter int PL_W        = 21,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = PL_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_TMR-1:0] tmr_en,
  input  logic [NUM_TMR-1:0] tmr_psel,
  input  logic               ext_pin,
  output logic               tick
);
  logic [NUM_TMR-1:0] hit;
  logic               run_w, start_w, ev_w, wrap_w, rise_w, fall_w;
  logic [PL_W-1:0]    pl_w, cnt_w;
  src_e               src_w;
  logic               unused_wr_msb;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_hit
    assign hit[i] = tmr_en[i] & tmr_psel[i];
  end
  assign run_w         = |hit;
  assign unused_wr_msb = wr_data[REG_W-1];

  tp_ctrl_reg #(.PL_W(PL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_pl(wr_data[PL_W-1:0]), .wr_src(wr_data[PL_W+1:PL_W]),
    .run(run_w), .pl(pl_w), .src(src_w)
  );

  tp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(rise_w), .fall(fall_w)
  );

  tp_src_sel u_src (
    .clk(clk), .rst_n(rst_n), .run(run_w), .src(src_w),
    .rise(rise_w), .fall(fall_w), .ev(ev_w)
  );

  tp_counter #(.PL_W(PL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_w), .ev(ev_w), .pl(pl_w),
    .cnt(cnt_w), .start(start_w), .wrap(wrap_w), .tick(tick)
  );

  assign rd_data = {1'b0, src_w, pl_w};
endmodule

// File: rtl/tp_checker.sv
`timescale 1ns/1ps
module tp_checker #(
  parameter int PL_W = 21
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_rst,
  input logic            run,
  input logic            start,
  input logic            ev,
  input logic            tick,
  input logic [PL_W-1:0] cnt,
  input logic [PL_W-1:0] pl,
  input logic [1:0]      src
);
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev) && !$past(start) && $past(cnt) != '0) |-> cnt == $past(cnt) - 1'b1);

  assert_reload_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(pl));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(cnt));

  assert_tick_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run));

  assert_div2_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'b00 && ev) |=> !ev);

  assert_no_event_rsv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'b11) |-> !ev);

  assert_src_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(soft_rst)) |-> src == $past(src));
endmodule

bind timer_prescaler tp_checker #(.PL_W(PL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run_w),
  .start(start_w), .ev(ev_w), .tick(tick), .cnt(cnt_w), .pl(pl_w),
  .src(src_w)
);

// File: tb/test_timer_prescaler.sv
`timescale 1ns/1ps
module test_timer_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic [2:0]  tmr_en = '0;
  logic [2:0]  tmr_psel = '0;
  logic        ext_pin = 1'b0;
  logic        tick;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;
  bit done = 0;
  bit prev_tick = 0;

  always #2 clk = ~clk;

  timer_prescaler i_timer_prescaler (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_en(tmr_en),
    .tmr_psel(tmr_psel), .ext_pin(ext_pin), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int unsigned m_pre = 0;
  int unsigned m_src = 0;
  int unsigned m_cnt = 0;
  int          m_phase = 0;
  bit          m_run_prev = 0;
  bit          m_tick = 0;
  bit          hist[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_src = 0; m_cnt = 0; m_phase = 0;
      m_run_prev = 0; m_tick = 0; hist = '{0, 0, 0};
    end else begin
      bit run, ev, started;
      run = (tmr_en & tmr_psel) != 0;
      case (m_src)
        0: ev = run && (m_phase % 2 == 1);
        1: ev = run && hist[1] && !hist[2];
        2: ev = run && !hist[1] && hist[2];
        default: ev = 0;
      endcase
      started = run && !m_run_prev;
      m_tick = 0;
      if (started) m_cnt = m_pre;
      else if (ev) begin
        if (m_cnt == 0) begin m_cnt = m_pre; m_tick = 1; end
        else m_cnt = m_cnt - 1;
      end
      m_phase = run ? m_phase + 1 : 0;
      m_run_prev = run;
      if (soft_rst) begin m_pre = 0; m_src = 0; end
      else if (wr_en) begin
        m_pre = wr_data[20:0];
        if (!run) m_src = wr_data[22:21];
      end
      hist.push_front(ext_pin);
      void'(hist.pop_back());
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check(rd_data == {1'b0, m_src[1:0], m_pre[20:0]}, "R1 model readback", rd_data, {m_src[1:0], m_pre[20:0]});
      check(tick == m_tick, "R4 model tick", tick, m_tick);
      check(!(tick && prev_tick), "R4 tick width", 2, 1);
      if (tick) tick_cnt++;
      prev_tick = tick;
    end
  end

  task automatic wr(input int unsigned pre, input int unsigned src);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {1'b0, src[1:0], pre[20:0]};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      ext_pin = 1'b1; cyc(4);
      ext_pin = 1'b0; cyc(4);
    end
  endtask

  initial begin
    int t0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check(rd_data == 24'h0, "R1 reset readback", rd_data, 0);
    check(tick == 1'b0, "R1 reset tick", tick, 0);

    wr(32'hFFFFFFFF, 3);
    cyc(1);
    check(rd_data == 24'h7FFFFF, "R1 top bit reads 0", rd_data, 24'h7FFFFF);

    @(negedge clk); soft_rst = 1'b1; wr_en = 1'b1; wr_data = 24'h123456;
    @(negedge clk); soft_rst = 1'b0; wr_en = 1'b0;
    check(rd_data == 24'h0, "R2 soft reset", rd_data, 0);

    // R7 internal source, reload 3: 66 run clocks -> 33 events -> 8 ticks
    wr(3, 0);
    t0 = tick_cnt;
    tmr_en = 3'b010; tmr_psel = 3'b010;
    cyc(66);
    tmr_en = 0; tmr_psel = 0;
    cyc(3);
    check(tick_cnt - t0 == 8, "R4 R7 divide by 4", tick_cnt - t0, 8);

    // R3 enable and select on different timers
    t0 = tick_cnt;
    tmr_en = 3'b001; tmr_psel = 3'b100;
    cyc(40);
    tmr_en = 0; tmr_psel = 0;
    cyc(2);
    check(tick_cnt - t0 == 0, "R3 mismatched timers", tick_cnt - t0, 0);

    // R4 reload 0: every event ticks; 20 clocks -> 10 events
    wr(0, 0);
    t0 = tick_cnt;
    tmr_en = 3'b100; tmr_psel = 3'b100;
    cyc(20);
    tmr_en = 0; tmr_psel = 0;
    cyc(3);
    check(tick_cnt - t0 == 10, "R4 reload zero", tick_cnt - t0, 10);

    // R10 source write while running is dropped, reload taken
    wr(5, 0);
    tmr_en = 3'b001; tmr_psel = 3'b001;
    cyc(2);
    wr(7, 1);
    cyc(1);
    check(rd_data == 24'h000007, "R10 source frozen", rd_data, 7);
    tmr_en = 0; tmr_psel = 0;
    cyc(2);

    // R8 rising edges, reload 2: 6 edges -> 2 ticks
    wr(2, 1);
    ext_pin = 1'b0; cyc(5);
    t0 = tick_cnt;
    tmr_en = 3'b001; tmr_psel = 3'b001;
    cyc(2);
    pulses(6);
    cyc(4);
    tmr_en = 0; tmr_psel = 0;
    cyc(2);
    check(tick_cnt - t0 == 2, "R8 rising edges", tick_cnt - t0, 2);

    // R8 falling edges, reload 1: 6 edges -> 3 ticks
    wr(1, 2);
    cyc(5);
    t0 = tick_cnt;
    tmr_en = 3'b011; tmr_psel = 3'b010;
    cyc(2);
    pulses(6);
    cyc(4);
    tmr_en = 0; tmr_psel = 0;
    cyc(2);
    check(tick_cnt - t0 == 3, "R8 falling edges", tick_cnt - t0, 3);

    // R9 reserved source
    wr(0, 3);
    t0 = tick_cnt;
    tmr_en = 3'b111; tmr_psel = 3'b111;
    pulses(4);
    tmr_en = 0; tmr_psel = 0;
    cyc(2);
    check(tick_cnt - t0 == 0, "R9 no source", tick_cnt - t0, 0);

    // R6 hold, R5 reload on restart, reload 3 internal
    wr(3, 0);
    tmr_en = 3'b010; tmr_psel = 3'b010;
    cyc(4);
    tmr_en = 0; tmr_psel = 0;
    t0 = tick_cnt;
    cyc(20);
    check(tick_cnt - t0 == 0, "R6 stopped no tick", tick_cnt - t0, 0);
    tmr_en = 3'b010; tmr_psel = 3'b010;
    cyc(7);
    check(tick_cnt - t0 == 0, "R5 restart reloads", tick_cnt - t0, 0);
    cyc(2);
    check(tick_cnt - t0 == 1, "R5 first tick after restart", tick_cnt - t0, 1);
    tmr_en = 0; tmr_psel = 0;
    cyc(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule